// File: doc/BRIEF.md
# Audio DSP Program Sequencer

This block steps the instruction counter of a fixed-length audio DSP program and keeps each pass aligned to the incoming frame clock. A programmable length picks one of four program sizes. A programmable divider lets one program pass span one, two, four or eight input frames, which suits decimating designs that consume several input samples per output frame.

The block also drives the transfer of core results into the serial output registers. By default the transfer happens once at the end of each pass. Optionally it follows every edge of the output frame clock, so that results can be moved several times per input frame. While the run bit is low, the output registers are held cleared and no transfer is issued. This keeps the outputs silent from power-up until software enables the block.

Top module: `dsp_seq`

## Requirements
- R1: `len_sel` sets the pass length L: 00 gives 1536 steps, 01 gives 768, 10 gives 384 and 11 gives 192. While running, `pc_o` advances by one per clock from 0. `eos_o` is high in the cycle where `pc_o` is at or beyond L-1. If L shrinks below the current step, that step counts as the last.
- R2: When the last step has been executed and no restart is pending, `pc_o` holds its value and `idle_o` stays 1 until the next sync event.
- R3: Each input frame-clock level is sampled through two flops, and rising edges are detected on the sampled level. `div_sel` picks the divide ratio N: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. The first detected rising edge after reset is a sync event, and after that every N-th rising edge is one. A sync event sets `pc_o` to 0, clears `idle_o` and pulses `frame_start_o` high for one cycle.
- R4: A sync event that arrives while running with `pc_o` below L-1 sets `overrun_o`. The flag stays set until reset.
- R5: With `latch_sel`=0 and `run_en`=1, `latch_stb_o` pulses for one cycle, in the cycle after `eos_o`.
- R6: With `latch_sel`=1 and `run_en`=1, `latch_stb_o` pulses once for each rising and each falling edge of the two-flop-sampled output frame clock, and ignores `eos_o`.
- R7: While `run_en`=0, `clear_o` is 1 in the next cycle and `latch_stb_o` stays 0.
- R8: Reset state: `pc_o`=0, `idle_o`=1, `overrun_o`=0, `frame_start_o`=0, `eos_o`=0, `latch_stb_o`=0 and `clear_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk_in | input | 1 | Input frame clock (asynchronous) |
| lrclk_out | input | 1 | Output frame clock (asynchronous) |
| len_sel | input | 2 | Program length code |
| div_sel | input | 2 | Frame-clock divide code |
| latch_sel | input | 1 | Transfer source: 0 end of pass, 1 output frame-clock edges |
| run_en | input | 1 | 0 holds outputs cleared |
| pc_o | output | 11 | Program counter |
| eos_o | output | 1 | Last step of the pass |
| frame_start_o | output | 1 | One-cycle pulse when a pass restarts |
| idle_o | output | 1 | Waiting for a sync event |
| overrun_o | output | 1 | Sticky early-sync flag |
| latch_stb_o | output | 1 | Transfer strobe to the output registers |
| clear_o | output | 1 | Clear for accumulators and output registers |

## Verification
Directed phases pair each length code with a frame period that is slightly longer than the pass, so the counter must stop and wait, and one phase uses a period that is too short, so passes are cut off and the overrun flag must latch. Divider codes are each run with a frame period scaled to match, which separates a correct edge count from an off-by-one. The output-clock strobe mode runs with an output clock that is faster than, and unrelated to, the pass. Any strobe that follows end-of-pass instead of clock edges is then exposed. Random phases draw all codes and both periods, including length and divider changes in the middle of a pass.

// File: rtl/dsp_seq_pkg.sv
package dsp_seq_pkg;
  localparam int unsigned FULL_STEPS = 1536;
  localparam int unsigned PC_W       = $clog2(FULL_STEPS);
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned DIV_CNT_W  = (1 << SEL_W) - 1;

  typedef logic [PC_W-1:0] pc_t;

  function automatic pc_t last_step(input int unsigned full, input logic [SEL_W-1:0] code);
    last_step = pc_t'((full >> code) - 1);
  endfunction
endpackage

// File: rtl/seq_edge_sync.sv
module seq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  assign chain_d[0] = async_i;
  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    assign chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/seq_sync_div.sv
module seq_sync_div
  import dsp_seq_pkg::*;
#(
  parameter int unsigned SW = SEL_W,
  localparam int unsigned CW = (1 << SW) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic [SW-1:0] div_sel,
  output logic          sync_o
);
  logic [CW-1:0] cnt_q, cnt_d, top_val;

  always_comb begin
    top_val = CW'((32'd1 << div_sel) - 32'd1);
    cnt_d   = cnt_q;
    if (rise_i) begin
      if (cnt_q >= top_val) cnt_d = '0;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (rise_i) cnt_q <= cnt_d;
  end

  assign sync_o = rise_i && (cnt_q == '0);
endmodule

// File: rtl/seq_pc_gen.sv
module seq_pc_gen
  import dsp_seq_pkg::*;
#(
  parameter int unsigned STEPS = FULL_STEPS,
  localparam int unsigned PW = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [SEL_W-1:0] len_sel,
  output logic [PW-1:0]    pc_o,
  output logic             eos_o,
  output logic             idle_o,
  output logic             start_o,
  output logic             ovr_o
);
  logic [PW-1:0] pc_q, pc_d, last;
  logic          idle_q, idle_d, ovr_q, ovr_d, st_q, st_d, at_end;

  always_comb begin
    last   = PW'((STEPS >> len_sel) - 1);
    at_end = (pc_q >= last);
    pc_d   = pc_q;
    idle_d = idle_q;
    ovr_d  = ovr_q;
    st_d   = 1'b0;
    if (sync_i) begin
      pc_d   = '0;
      idle_d = 1'b0;
      st_d   = 1'b1;
      if (!idle_q && !at_end) ovr_d = 1'b1;
    end else if (!idle_q) begin
      if (at_end) idle_d = 1'b1;
      else        pc_d   = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      idle_q <= 1'b1;
      ovr_q  <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      idle_q <= idle_d;
      ovr_q  <= ovr_d;
      st_q   <= st_d;
    end
  end

  assign pc_o    = pc_q;
  assign idle_o  = idle_q;
  assign ovr_o   = ovr_q;
  assign start_o = st_q;
  assign eos_o   = !idle_q && at_end;
endmodule

// File: rtl/dsp_seq.sv
module dsp_seq
  import dsp_seq_pkg::*;
#(
  parameter int unsigned STEPS   = FULL_STEPS,
  parameter int unsigned SYNC_FF = 2,
  localparam int unsigned PW = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrclk_in,
  input  logic             lrclk_out,
  input  logic [SEL_W-1:0] len_sel,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             latch_sel,
  input  logic             run_en,
  output logic [PW-1:0]    pc_o,
  output logic             eos_o,
  output logic             frame_start_o,
  output logic             idle_o,
  output logic             overrun_o,
  output logic             latch_stb_o,
  output logic             clear_o
);
  logic in_rise, in_fall, out_rise, out_fall, sync_evt;
  logic lat_q, lat_d, clr_q, clr_d;

  seq_edge_sync #(.STAGES(SYNC_FF)) u_in_sync (
    .clk(clk), .rst_n(rst_n), .async_i(lrclk_in), .rise_o(in_rise), .fall_o(in_fall)
  );

  seq_edge_sync #(.STAGES(SYNC_FF)) u_out_sync (
    .clk(clk), .rst_n(rst_n), .async_i(lrclk_out), .rise_o(out_rise), .fall_o(out_fall)
  );

  seq_sync_div #(.SW(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .rise_i(in_rise), .div_sel(div_sel), .sync_o(sync_evt)
  );

  seq_pc_gen #(.STEPS(STEPS)) u_pc (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_evt), .len_sel(len_sel),
    .pc_o(pc_o), .eos_o(eos_o), .idle_o(idle_o), .start_o(frame_start_o), .ovr_o(overrun_o)
  );

  always_comb begin
    clr_d = ~run_en;
    lat_d = run_en & (latch_sel ? (out_rise | out_fall) : eos_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      clr_q <= 1'b1;
    end else begin
      lat_q <= lat_d;
      clr_q <= clr_d;
    end
  end

  assign latch_stb_o = lat_q;
  assign clear_o     = clr_q;

  logic unused_fall;
  assign unused_fall = in_fall;
endmodule

// File: rtl/dsp_seq_chk.sv
module dsp_seq_chk #(
  parameter int unsigned PW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          latch_sel,
  input logic          run_en,
  input logic [PW-1:0] pc_o,
  input logic          eos_o,
  input logic          frame_start_o,
  input logic          idle_o,
  input logic          overrun_o,
  input logic          latch_stb_o,
  input logic          clear_o
);
  // R1
  eos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eos_o |=> (idle_o || pc_o == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |=> ((idle_o && $stable(pc_o)) || (frame_start_o && pc_o == '0)));

  // R3
  start_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (pc_o == '0 && !idle_o));

  // R4
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  // R5
  eos_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_o && !latch_sel && run_en) |=> latch_stb_o);

  // R7
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> !latch_stb_o);
endmodule

bind dsp_seq dsp_seq_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_sel(latch_sel), .run_en(run_en),
  .pc_o(pc_o), .eos_o(eos_o), .frame_start_o(frame_start_o), .idle_o(idle_o),
  .overrun_o(overrun_o), .latch_stb_o(latch_stb_o), .clear_o(clear_o)
);

// File: tb/dsp_seq_test.sv
module dsp_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrclk_in = 1'b0, lrclk_out = 1'b0;
  logic [1:0] len_sel = 2'b11, div_sel = 2'b00;
  logic latch_sel = 1'b0, run_en = 1'b0;
  logic [10:0] pc_o;
  logic eos_o, frame_start_o, idle_o, overrun_o, latch_stb_o, clear_o;

  int checks = 0, errors = 0;
  int hp_in = 100, hp_out = 40, in_cnt = 0, out_cnt = 0;
  bit checking = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  dsp_seq uut (
    .clk(clk), .rst_n(rst_n), .lrclk_in(lrclk_in), .lrclk_out(lrclk_out),
    .len_sel(len_sel), .div_sel(div_sel), .latch_sel(latch_sel), .run_en(run_en),
    .pc_o(pc_o), .eos_o(eos_o), .frame_start_o(frame_start_o), .idle_o(idle_o),
    .overrun_o(overrun_o), .latch_stb_o(latch_stb_o), .clear_o(clear_o)
  );

  // reference model, built from the requirements
  bit ms1, ms2, mp, os1, os2, op;
  bit midle, movr, mfs, mlat, mclr;
  int mpc, mcnt;

  function automatic int last_of(input logic [1:0] c);
    return (1536 >> c) - 1;
  endfunction

  function automatic bit eos_of(input int pc, input bit idle, input logic [1:0] c);
    return !idle && (pc >= last_of(c));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; mp = 0; os1 = 0; os2 = 0; op = 0;
      mpc = 0; midle = 1; movr = 0; mfs = 0; mlat = 0; mclr = 1; mcnt = 0;
    end else begin
      bit rin, oedge, e, sy;
      int n;
      rin   = ms2 && !mp;
      oedge = os2 ^ op;
      e     = eos_of(mpc, midle, len_sel);
      n     = 1 << div_sel;
      sy    = rin && (mcnt == 0);
      if (rin) mcnt = (mcnt >= n - 1) ? 0 : mcnt + 1;
      mlat = run_en && (latch_sel ? oedge : e);
      mclr = !run_en;
      mfs  = sy;
      if (sy) begin
        if (!midle && mpc < last_of(len_sel)) movr = 1;
        mpc = 0; midle = 0;
      end else if (!midle) begin
        if (mpc >= last_of(len_sel)) midle = 1;
        else mpc = mpc + 1;
      end
      mp = ms2; ms2 = ms1; ms1 = lrclk_in;
      op = os2; os2 = os1; os1 = lrclk_out;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors <= 20)
        $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // frame clock generators
  always @(negedge clk) begin
    if (in_cnt >= hp_in - 1) begin in_cnt = 0; lrclk_in = ~lrclk_in; end
    else in_cnt++;
    if (out_cnt >= hp_out - 1) begin out_cnt = 0; lrclk_out = ~lrclk_out; end
    else out_cnt++;
  end

  // compare away from both clock edges
  always @(negedge clk) begin
    #8;
    if (checking && !done) begin
      chk("R1", "pc", int'(pc_o), mpc);
      chk("R1", "eos", int'(eos_o), int'(eos_of(mpc, midle, len_sel)));
      chk("R2", "idle", int'(idle_o), int'(midle));
      chk("R3", "frame_start", int'(frame_start_o), int'(mfs));
      chk("R4", "overrun", int'(overrun_o), int'(movr));
      if (latch_sel) chk("R6", "latch_stb", int'(latch_stb_o), int'(mlat));
      else           chk("R5", "latch_stb", int'(latch_stb_o), int'(mlat));
      chk("R7", "clear", int'(clear_o), int'(mclr));
    end
  end

  task automatic phase(input logic [1:0] l, input logic [1:0] d, input int hi, input int ho,
                       input logic src, input logic run, input int cycles);
    @(negedge clk);
    len_sel = l; div_sel = d; hp_in = hi; hp_out = ho; latch_sel = src; run_en = run;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic reset_check();
    #8;
    chk("R8", "reset pc", int'(pc_o), 0);
    chk("R8", "reset idle", int'(idle_o), 1);
    chk("R8", "reset overrun", int'(overrun_o), 0);
    chk("R8", "reset frame_start", int'(frame_start_o), 0);
    chk("R8", "reset eos", int'(eos_o), 0);
    chk("R8", "reset latch", int'(latch_stb_o), 0);
    chk("R8", "reset clear", int'(clear_o), 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    reset_check();
    @(negedge clk);
    rst_n = 1'b1;
    checking = 1'b1;
    // R7 clear mode, then R1/R2 with idle gaps on the shortest pass
    phase(2'b11, 2'b00, 100, 40, 1'b0, 1'b0, 1500);
    phase(2'b11, 2'b00, 100, 40, 1'b0, 1'b1, 4000);
    // R3 divide by two
    phase(2'b11, 2'b01, 50, 33, 1'b0, 1'b1, 4000);
    // R4 frames too short for a full pass
    phase(2'b00, 2'b00, 300, 40, 1'b0, 1'b1, 5000);
    // mid-run reset clears the sticky flag
    @(negedge clk); rst_n = 1'b0;
    reset_check();
    @(negedge clk); rst_n = 1'b1;
    // R6 output-clock strobes, divide by four
    phase(2'b01, 2'b10, 100, 23, 1'b1, 1'b1, 8000);
    // divide by eight, pass of 384
    phase(2'b10, 2'b11, 25, 37, 1'b0, 1'b1, 6000);
    // full-length pass with slack
    phase(2'b00, 2'b00, 800, 51, 1'b1, 1'b1, 6000);
    for (int i = 0; i < 8; i++) begin
      phase(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), int'($urandom_range(12, 500)),
            int'($urandom_range(5, 80)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 5) != 0), int'($urandom_range(3000, 9000)));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R1: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule